// File: doc/BRIEF.md
# Seven-Line Configurable I/O Port with Shared PWM

This block is a seven-line general-purpose I/O port meant to sit beside a key-sensing engine. Each line is set as an input or an output through a direction register. An output line is driven from one of two sources: its key-detection channel or a bit of a host-written value register. That source is then passed through either as a plain level or gated by one 8-bit PWM generator that all lines share. A per-line inversion bit sets the output polarity.

Lines configured as inputs are synchronized and captured into a status register. Any level change on an input line pulls an active-low change output, which stays low until the host reads the status register.

A strap input chooses the reset defaults. When it is low, every line comes up as an input. When it is high, every line comes up as a plain-level output that follows its detection channel, so the port can run without a host. The host reaches the port through a simple single-cycle register bus. The serial host link and the sensing front end are outside this block.

Top module: `io_port_pwm`

## Requirements
- R1: `padOe[i]` equals bit i of the direction register (address 0); 1 makes line i an output and 0 makes it an input.
- R2: After reset with `strapStandalone` low, every register at addresses 0 to 5 reads 0. All lines are inputs and `changeN` is high.
- R3: After reset with `strapStandalone` high, the direction register reads 0x7F and the other registers read 0. Each `padOut[i]` then follows `detect[i]`.
- R4: For an output line i, bit i of the source register (address 1) selects the source: 0 selects `detect[i]` and 1 selects bit i of the user value register (address 4).
- R5: For an output line i, bit i of the polarity register (address 3) inverts the final level on `padOut[i]`.
- R6: For an output line i, bit i of the PWM-enable register (address 2) gates the selected source with the PWM signal. The PWM signal is high when a free-running 8-bit counter is below the duty register (address 5). The counter is 0 in the first cycle after reset and advances by one every clock. A duty of 0 gives a constant low before inversion.
- R7: For an input line, `padOut[i]` is 0 whatever the source, PWM, polarity and user value bits hold.
- R8: Reading address 6 returns the synchronized input levels, with bits of output lines reading 0. A change on `padIn` appears there after the third rising clock edge.
- R9: `changeN` goes low after the clock edge at which the status register captures a level that differs from the previous one on an input line. It stays low until a read of address 6 is clocked. If a new change lands on the same edge as that read, `changeN` stays low.
- R10: Addresses 0 to 5 read back the last value written, with bit 7 reading 0 except for the duty register. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapStandalone | input | 1 | Selects standalone defaults while reset is held |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a status read clears the change flag) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from `addr` |
| detect | input | 7 | Key-detection channels |
| padIn | input | 7 | Pad input levels |
| padOut | output | 7 | Pad output levels |
| padOe | output | 7 | Pad output enables |
| changeN | output | 1 | Active-low input change indication |

## Verification
The hardest case to reach is an input edge that arrives at the status register on the same clock edge as the host's status read. Changes that land on output lines, or on lines that are being switched between input and output, are also awkward. The bench drives a long stretch of randomly timed pad toggles, status reads and direction rewrites against a behavioural model. That model delays the pad inputs through a two-deep queue and tracks the pending flag independently, so many of these collisions occur and are compared on every clock. Sweeps of the PWM duty across 0, a middle value and 255 cover both ends of the comparator.

// File: rtl/ioport_pkg.sv
`timescale 1ns/1ps
package ioport_pkg;
  localparam int NLINES = 7;
  localparam int DUTYW  = 8;
  localparam int ADDRW  = 3;
  localparam int DATAW  = DUTYW;

  typedef enum logic [ADDRW-1:0] {
    REG_DIR  = 3'd0,
    REG_SRC  = 3'd1,
    REG_PWM  = 3'd2,
    REG_POL  = 3'd3,
    REG_USER = 3'd4,
    REG_DUTY = 3'd5,
    REG_STAT = 3'd6,
    REG_NONE = 3'd7
  } regAddr_t;

  typedef struct packed {
    logic [NLINES-1:0] dir;
    logic [NLINES-1:0] src;
    logic [NLINES-1:0] pwmEn;
    logic [NLINES-1:0] invert;
    logic [NLINES-1:0] userOut;
    logic [DUTYW-1:0]  duty;
  } portCfg_t;

  typedef struct packed {
    logic statusRead;
  } ctrlStrobe_t;
endpackage

// File: rtl/ioport_ctrl.sv
`timescale 1ns/1ps
module ioport_ctrl
  import ioport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapStandalone,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDRW-1:0]  addr,
  input  logic [DATAW-1:0]  wrData,
  input  logic [NLINES-1:0] inStat,
  output portCfg_t          cfg,
  output ctrlStrobe_t       strobe,
  output logic [DATAW-1:0]  rdData
);
  localparam int PADW = DATAW - NLINES;

  regAddr_t regSel;
  assign regSel = regAddr_t'(addr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg     <= '0;
      cfg.dir <= strapStandalone ? '1 : '0;
    end else if (wrEn) begin
      case (regSel)
        REG_DIR:  cfg.dir     <= wrData[NLINES-1:0];
        REG_SRC:  cfg.src     <= wrData[NLINES-1:0];
        REG_PWM:  cfg.pwmEn   <= wrData[NLINES-1:0];
        REG_POL:  cfg.invert  <= wrData[NLINES-1:0];
        REG_USER: cfg.userOut <= wrData[NLINES-1:0];
        REG_DUTY: cfg.duty    <= wrData;
        default: ;
      endcase
    end
  end

  assign strobe.statusRead = rdEn && (regSel == REG_STAT);

  always_comb begin
    case (regSel)
      REG_DIR:  rdData = {{PADW{1'b0}}, cfg.dir};
      REG_SRC:  rdData = {{PADW{1'b0}}, cfg.src};
      REG_PWM:  rdData = {{PADW{1'b0}}, cfg.pwmEn};
      REG_POL:  rdData = {{PADW{1'b0}}, cfg.invert};
      REG_USER: rdData = {{PADW{1'b0}}, cfg.userOut};
      REG_DUTY: rdData = cfg.duty;
      REG_STAT: rdData = {{PADW{1'b0}}, inStat};
      default:  rdData = '0;
    endcase
  end

  // R2
  normal_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rstN) && !$past(strapStandalone)) |-> (cfg == '0));

  // R3
  strap_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rstN) && $past(strapStandalone)) |->
      (cfg.dir == '1 && cfg.src == '0 && cfg.pwmEn == '0 && cfg.invert == '0));
endmodule

// File: rtl/ioport_datapath.sv
`timescale 1ns/1ps
module ioport_datapath
  import ioport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portCfg_t          cfg,
  input  ctrlStrobe_t       strobe,
  input  logic [NLINES-1:0] detect,
  input  logic [NLINES-1:0] padIn,
  output logic [NLINES-1:0] padOut,
  output logic [NLINES-1:0] padOe,
  output logic [NLINES-1:0] inStat,
  output logic              changeN
);
  localparam logic [DUTYW-1:0] CNT_ONE = {{(DUTYW-1){1'b0}}, 1'b1};

  logic [DUTYW-1:0]  pwmCnt;
  logic              pwmHigh;
  logic [NLINES-1:0] syncA, syncB, statReg, inDiff;
  logic              pending;

  always_ff @(posedge clk) begin
    if (!rstN) pwmCnt <= '0;
    else       pwmCnt <= pwmCnt + CNT_ONE;
  end
  assign pwmHigh = pwmCnt < cfg.duty;

  assign inDiff = (syncB ^ statReg) & ~cfg.dir;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      statReg <= '0;
      pending <= 1'b0;
    end else begin
      syncA   <= padIn;
      syncB   <= syncA;
      statReg <= syncB;
      if (|inDiff)                pending <= 1'b1;
      else if (strobe.statusRead) pending <= 1'b0;
    end
  end

  assign inStat  = statReg & ~cfg.dir;
  assign changeN = ~pending;
  assign padOe   = cfg.dir;

  for (genvar i = 0; i < NLINES; i++) begin : gLine
    logic srcBit, lvlBit;
    assign srcBit    = cfg.src[i] ? cfg.userOut[i] : detect[i];
    assign lvlBit    = cfg.pwmEn[i] ? (srcBit & pwmHigh) : srcBit;
    assign padOut[i] = cfg.dir[i] & (lvlBit ^ cfg.invert[i]);
  end

  // R6
  duty_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.duty == '0) |-> ((padOut & cfg.dir & cfg.pwmEn & ~cfg.invert) == '0));

  // R8
  status_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (statReg == $past(syncB)));

  // R9
  change_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!changeN && !strobe.statusRead) |=> !changeN);
endmodule

// File: rtl/io_port_pwm.sv
`timescale 1ns/1ps
module io_port_pwm
  import ioport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapStandalone,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDRW-1:0]  addr,
  input  logic [DATAW-1:0]  wrData,
  output logic [DATAW-1:0]  rdData,
  input  logic [NLINES-1:0] detect,
  input  logic [NLINES-1:0] padIn,
  output logic [NLINES-1:0] padOut,
  output logic [NLINES-1:0] padOe,
  output logic              changeN
);
  portCfg_t          cfg;
  ctrlStrobe_t       strobe;
  logic [NLINES-1:0] inStat;

  ioport_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .strapStandalone(strapStandalone),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .inStat(inStat), .cfg(cfg), .strobe(strobe), .rdData(rdData)
  );

  ioport_datapath uData (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe),
    .detect(detect), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .inStat(inStat), .changeN(changeN)
  );
endmodule

// File: tb/io_port_pwm_test.sv
`timescale 1ns/1ps
module io_port_pwm_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strapStandalone = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [6:0] detect = '0, padIn = '0;
  logic [6:0] padOut, padOe;
  logic       changeN;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  int mDir, mSrc, mPwm, mPol, mUser, mDuty, mCnt, mStat, diffBits;
  int inQ[$];
  bit mPend;

  always #2.5 clk = ~clk;

  io_port_pwm uut (
    .clk(clk), .rstN(rstN), .strapStandalone(strapStandalone),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .detect(detect), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .changeN(changeN)
  );

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  function automatic int expPad();
    int r = 0;
    for (int i = 0; i < 7; i++) begin
      int b;
      if (mSrc[i]) b = mUser[i]; else b = detect[i];
      if (mPwm[i]) b = b & ((mCnt < mDuty) ? 1 : 0);
      b = b ^ mPol[i];
      if (mDir[i]) r |= (b << i);
    end
    return r;
  endfunction

  function automatic int expRd(int a);
    case (a)
      0: return mDir;
      1: return mSrc;
      2: return mPwm;
      3: return mPol;
      4: return mUser;
      5: return mDuty;
      6: return mStat & ~mDir & 127;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, advanced at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mDir = strapStandalone ? 127 : 0;
      mSrc = 0; mPwm = 0; mPol = 0; mUser = 0; mDuty = 0;
      mCnt = 0; mStat = 0; mPend = 0;
      inQ = '{0, 0};
    end else begin
      diffBits = (inQ[0] ^ mStat) & ~mDir & 127;
      if (rdEn && addr == 3'd6) mPend = 0;
      if (diffBits != 0) mPend = 1;
      mStat = inQ.pop_front();
      inQ.push_back(int'(padIn));
      mCnt = (mCnt + 1) % 256;
      if (wrEn) case (addr)
        3'd0: mDir  = wrData & 127;
        3'd1: mSrc  = wrData & 127;
        3'd2: mPwm  = wrData & 127;
        3'd3: mPol  = wrData & 127;
        3'd4: mUser = wrData & 127;
        3'd5: mDuty = wrData;
        default: ;
      endcase
    end
  end

  // compare half a nanosecond before each rising edge
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      chk("R1 padOe", padOe, mDir);
      chk(strapStandalone ? "R3 padOut" : "R4 R5 R6 R7 padOut", padOut, expPad());
      chk("R9 changeN", changeN, mPend ? 0 : 1);
      if (rdEn) chk(addr == 3'd6 ? "R8 status" : "R2 R10 readback", rdData, expRd(addr));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wrEn = 1; rdEn = 0; addr = 3'(a); wrData = 8'(d);
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(int a);
    @(negedge clk); rdEn = 1; wrEn = 0; addr = 3'(a);
    @(negedge clk); rdEn = 0;
  endtask

  task automatic doReset(bit strap);
    @(negedge clk); rstN = 0; strapStandalone = strap;
    idle(3);
    rstN = 1;
  endtask

  initial begin
    // R3 standalone defaults: outputs follow detect
    doReset(1);
    for (int k = 0; k < 6; k++) rd(k);
    for (int k = 0; k < 40; k++) begin @(negedge clk); detect = 7'($urandom); end
    // R2 normal defaults
    doReset(0);
    strapStandalone = 0;
    for (int k = 0; k < 8; k++) rd(k);
    // R4 R5 source and polarity
    wr(0, 8'h7F); wr(1, 8'h0F); wr(4, 8'h55); wr(3, 8'h30);
    for (int k = 0; k < 30; k++) begin @(negedge clk); detect = 7'($urandom); end
    // R6 PWM at several duties
    wr(2, 8'h43); wr(5, 8'h40); idle(600);
    wr(5, 8'h00); idle(300);
    wr(5, 8'hFF); idle(300);
    // R7 input lines ignore masks
    wr(0, 8'h0F); wr(2, 8'h7F); wr(3, 8'h7F); wr(1, 8'h7F); wr(4, 8'h7F);
    idle(5);
    // R8 R9 input changes and reads
    @(negedge clk); padIn = 7'h50; idle(6); rd(6); idle(3);
    @(negedge clk); padIn = 7'h01; idle(6); rd(6);
    // R10 plus random collisions
    for (int k = 0; k < 4000; k++) begin
      int r;
      @(negedge clk);
      wrEn = 0; rdEn = 0;
      detect = 7'($urandom);
      if ($urandom_range(7) == 0) padIn = 7'($urandom);
      r = $urandom_range(11);
      if (r < 2) begin wrEn = 1; addr = 3'($urandom_range(7)); wrData = 8'($urandom); end
      else if (r < 4) begin rdEn = 1; addr = 3'd6; end
      else if (r < 5) begin rdEn = 1; addr = 3'($urandom_range(7)); end
    end
    @(negedge clk); wrEn = 0; rdEn = 0;
    idle(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule